// File: doc/BRIEF.md
# Gated Peripheral Clock Divider Bank

This block holds three independent programmable dividers, all clocked by the system clock. Each divider produces a one-cycle clock-enable pulse that acts as the reference tick for one peripheral group. The pulse period is the programmed division value plus one system-clock cycles. A single 32-bit configuration word holds an enable bit and a division value for every divider. Software writes the word over a minimal register bus that carries a write strobe, a privilege flag and write data. The stored contents are always visible on the read-data output.

Only supervisor-mode writes change the configuration. A divider accepts a new division value only in a write that also sets its enable bit. A write that leaves a divider disabled keeps the old division value. While a divider is disabled its counter is held at zero and its output stays low. When it is re-enabled, the first period is a full period. A new value written to a running divider takes effect at its next terminal count, so no shortened period is ever produced.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every enable bit and every division value is 0: cfg_rdata_o reads 0 and all div_tick_o bits are low.
- R2: A write with cfg_sup_i low has no effect on the stored word or on any output.
- R3: In a supervisor write whose enable bit for divider k is 0, the division field of divider k keeps its previous value.
- R4: Divider k has its division value in bits [9k+7:9k] and its enable at bit 9k+8. A supervisor write that sets bit 9k+8 stores both that enable and the division field, taking effect at the capturing clock edge.
- R5: While the enable of divider k is 0, div_tick_o[k] is low. This holds from the first cycle after the write that clears the enable.
- R6: With enable 1 and division value D, div_tick_o[k] is a one-cycle pulse every D+1 cycles. The first pulse comes D+1 cycles after the edge that enabled it.
- R7: Reads return the stored enables and division values, and bits 31:27 read as 0 whatever was written to them.
- R8: Disabling a divider clears its count, so after re-enabling it the first pulse again comes a full D+1 cycles after the enabling edge.
- R9: A new division value written to a running divider first affects the interval that starts at the next pulse of the old schedule. That pulse still occurs, including when the write is captured on the same edge as the pulse.
- R10: A division value of 0 makes div_tick_o[k] high in every cycle from the first cycle after the enabling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_sup_i | input | 1 | High for a supervisor-mode access |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Stored configuration word |
| div_tick_o | output | 3 | One clock-enable pulse per divider |

## Verification
The two functions that can meet in one cycle are a terminal count and a configuration write that changes the same divider's division value. The bench predicts the next pulse of a running divider from its own schedule model. It then times a supervisor write so that the write is captured on exactly that pulse's edge. The result is judged correct only if that pulse still appears and the following pulses are spaced by the new value plus one. A separate write placed between pulses covers the ordinary case.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int unsigned DEF_N_DIV  = 3;
  localparam int unsigned DEF_DIV_W  = 8;
  localparam int unsigned DEF_DATA_W = 32;

  // Lowest bit of the slot that holds divider idx (division field, then enable).
  function automatic int unsigned slot_lsb(input int unsigned idx, input int unsigned div_w);
    return idx * (div_w + 1);
  endfunction

  function automatic int unsigned en_pos(input int unsigned idx, input int unsigned div_w);
    return slot_lsb(idx, div_w) + div_w;
  endfunction
endpackage

// File: rtl/clkdiv_rst_sync.sv
`timescale 1ns/1ps
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int unsigned N_DIV  = DEF_N_DIV,
  parameter int unsigned DIV_W  = DEF_DIV_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic                        sup_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [N_DIV-1:0]            en_o,
  output logic [N_DIV-1:0][DIV_W-1:0] div_next_o,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int unsigned SLOT_W = DIV_W + 1;

  logic                        wr_ok;
  logic [N_DIV-1:0]            en_q, en_wr;
  logic [N_DIV-1:0][DIV_W-1:0] div_q, div_wr;

  assign wr_ok = we_i & sup_i;

  // Candidate contents for a privileged write: a division field is only
  // taken when the same write leaves its divider enabled.
  always_comb begin
    for (int k = 0; k < N_DIV; k++) begin
      en_wr[k]  = wdata_i[en_pos(k, DIV_W)];
      div_wr[k] = en_wr[k] ? wdata_i[slot_lsb(k, DIV_W) +: DIV_W] : div_q[k];
    end
  end

  always_comb begin
    div_next_o = wr_ok ? div_wr : div_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      div_q <= '0;
    end else if (wr_ok) begin
      en_q  <= en_wr;
      div_q <= div_wr;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_DIV; k++) begin
      rdata_o[k*SLOT_W +: SLOT_W] = {en_q[k], div_q[k]};
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/clkdiv_unit.sv
`timescale 1ns/1ps
module clkdiv_unit #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_next_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim_q, lim_d;
  logic             tick_q, tick_d;
  logic             term;
  logic             reload;

  assign term   = en_i && (cnt_q == lim_q);
  assign reload = !en_i || term;

  // The limit is sampled only at a terminal count or while idle, so a new
  // value never cuts a running interval short.
  always_comb begin
    cnt_d  = reload ? '0 : cnt_q + DIV_W'(1);
    lim_d  = reload ? div_next_i : lim_q;
    tick_d = term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q & en_i;
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int unsigned N_DIV  = DEF_N_DIV,
  parameter int unsigned DIV_W  = DEF_DIV_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sup_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic [N_DIV-1:0]  div_tick_o
);
  logic                        rst_n_sync;
  logic [N_DIV-1:0]            en;
  logic [N_DIV-1:0][DIV_W-1:0] div_next;

  clkdiv_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  clkdiv_regs #(
    .N_DIV  (N_DIV),
    .DIV_W  (DIV_W),
    .DATA_W (DATA_W)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .we_i       (cfg_we_i),
    .sup_i      (cfg_sup_i),
    .wdata_i    (cfg_wdata_i),
    .en_o       (en),
    .div_next_o (div_next),
    .rdata_o    (cfg_rdata_o)
  );

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    clkdiv_unit #(.DIV_W(DIV_W)) i_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_n_sync),
      .en_i       (en[g]),
      .div_next_i (div_next[g]),
      .tick_o     (div_tick_o[g])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
`timescale 1ns/1ps
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int unsigned N_DIV  = DEF_N_DIV,
  parameter int unsigned DIV_W  = DEF_DIV_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rst_n,
  input logic              cfg_we_i,
  input logic              cfg_sup_i,
  input logic [DATA_W-1:0] cfg_wdata_i,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic [N_DIV-1:0]  div_tick_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (cfg_rdata_o == '0 && div_tick_o == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  a_r2_user_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cfg_we_i && !cfg_sup_i) |=> $stable(cfg_rdata_o))
    else $error("R2 user write changed the configuration");

  for (genvar k = 0; k < N_DIV; k++) begin : g_chk
    localparam int unsigned LSB = slot_lsb(k, DIV_W);
    localparam int unsigned ENB = en_pos(k, DIV_W);

    a_r3_div_kept: assert property (@(posedge clk_i) disable iff (!rst_n)
      (cfg_we_i && cfg_sup_i && !cfg_wdata_i[ENB])
      |=> (cfg_rdata_o[LSB +: DIV_W] == $past(cfg_rdata_o[LSB +: DIV_W])))
      else $error("R3 division field changed by a disabling write");

    a_r4_slot_taken: assert property (@(posedge clk_i) disable iff (!rst_n)
      (cfg_we_i && cfg_sup_i && cfg_wdata_i[ENB])
      |=> (cfg_rdata_o[LSB +: DIV_W+1] == $past(cfg_wdata_i[LSB +: DIV_W+1])))
      else $error("R4 enabling write not stored");

    a_r5_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
      !cfg_rdata_o[ENB] |-> !div_tick_o[k])
      else $error("R5 tick while disabled");
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
  .N_DIV  (N_DIV),
  .DIV_W  (DIV_W),
  .DATA_W (DATA_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_n       (rst_n_sync),
  .cfg_we_i    (cfg_we_i),
  .cfg_sup_i   (cfg_sup_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .div_tick_o  (div_tick_o)
);

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
module test_clkdiv_bank;
  localparam int N      = 3;
  localparam int DW     = 8;
  localparam int DATA_W = 32;
  localparam int SLOT   = DW + 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic              cfg_we_i = 1'b0;
  logic              cfg_sup_i = 1'b0;
  logic [DATA_W-1:0] cfg_wdata_i = '0;
  logic [DATA_W-1:0] cfg_rdata_o;
  logic [N-1:0]      div_tick_o;

  clkdiv_bank #(.N_DIV(N), .DIV_W(DW), .DATA_W(DATA_W)) i_clkdiv_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sup_i   (cfg_sup_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .div_tick_o  (div_tick_o)
  );

  always #2.5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  typedef struct {
    int           at;
    logic [N-1:0] exp;
    string        tag;
  } item_t;
  item_t sb_q[$];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Schedule model per divider: pulses at a+m*p, old schedule up to sw.
  bit m_en[N];
  int m_div[N];
  int m_a[N], m_p[N], m_pa[N], m_pp[N], m_sw[N];

  function automatic logic exp_tick(int k, int c);
    int a, p;
    if (!m_en[k]) return 1'b0;
    if (c <= m_sw[k]) begin a = m_pa[k]; p = m_pp[k]; end
    else begin a = m_a[k]; p = m_p[k]; end
    return (c > a) && ((c - a) % p == 0);
  endfunction

  function automatic logic [DATA_W-1:0] fld(int k, bit e, int d);
    logic [DATA_W-1:0] v;
    v = '0;
    v[k*SLOT +: DW] = d[DW-1:0];
    v[k*SLOT + DW]  = e;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] model_rdata();
    logic [DATA_W-1:0] v;
    v = '0;
    for (int k = 0; k < N; k++) v |= fld(k, m_en[k], m_div[k]);
    return v;
  endfunction

  task automatic model_write(logic [DATA_W-1:0] d, bit sup, int w);
    if (!sup) return;
    for (int k = 0; k < N; k++) begin
      bit ne;
      int nd, t, n;
      ne = d[k*SLOT + DW];
      nd = int'(d[k*SLOT +: DW]);
      if (ne && !m_en[k]) begin
        m_pa[k] = w; m_pp[k] = 1; m_sw[k] = w; m_a[k] = w; m_p[k] = nd + 1;
        m_div[k] = nd;
      end else if (ne) begin
        n = (w - m_a[k] + m_p[k] - 1) / m_p[k];
        t = m_a[k] + n * m_p[k];
        m_pa[k] = m_a[k]; m_pp[k] = m_p[k]; m_sw[k] = t;
        m_a[k] = t; m_p[k] = nd + 1; m_div[k] = nd;
      end
      m_en[k] = ne;
    end
  endtask

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic check_rdata(string tag);
    logic [DATA_W-1:0] e;
    e = model_rdata();
    check(cfg_rdata_o === e, tag, cfg_rdata_o, e);
  endtask

  task automatic do_write(logic [DATA_W-1:0] d, bit sup);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sup_i = sup; cfg_wdata_i = d;
    @(posedge clk_i);
    #1;
    cfg_we_i = 1'b0; cfg_sup_i = 1'b0; cfg_wdata_i = '0;
    model_write(d, sup, cyc);
  endtask

  // Driver: push the expected tick vector for n cycles, then let them pass.
  task automatic expect_run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.at = cyc + i;
      it.tag = tag;
      for (int k = 0; k < N; k++) it.exp[k] = exp_tick(k, cyc + i);
      sb_q.push_back(it);
    end
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  // Monitor: pop and compare items as their cycle comes up.
  always @(negedge clk_i) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      item_t it;
      it = sb_q.pop_front();
      if (it.at == cyc) check(div_tick_o === it.exp, it.tag, div_tick_o, it.exp);
      else check(1'b0, {it.tag, " missed sample"}, it.at, cyc);
    end
  end

  initial begin
    int t;
    for (int k = 0; k < N; k++) begin
      m_en[k] = 0; m_div[k] = 0; m_a[k] = 0; m_p[k] = 1;
      m_pa[k] = 0; m_pp[k] = 1; m_sw[k] = 0;
    end
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
    #1;
    check_rdata("R1 reset word");
    expect_run(6, "R1 reset ticks");

    do_write(fld(0, 1, 3), 1'b0);
    check_rdata("R2 user write word");
    expect_run(10, "R2 user write ticks");

    do_write(fld(0, 1, 3), 1'b1);
    check_rdata("R4 enable with value");
    expect_run(14, "R6 period four");

    do_write(fld(0, 1, 3) | fld(1, 1, 0), 1'b1);
    check_rdata("R4 second slot");
    expect_run(8, "R10 divide by one");

    do_write(fld(0, 1, 3) | fld(1, 1, 0) | fld(2, 0, 5), 1'b1);
    check_rdata("R3 disabled value dropped");
    expect_run(6, "R3 ticks");

    do_write(fld(0, 0, 7) | fld(1, 1, 0), 1'b1);
    check_rdata("R3 R5 disable keeps value");
    expect_run(9, "R5 disabled quiet");

    do_write(fld(0, 1, 3) | fld(1, 1, 0), 1'b1);
    check_rdata("R8 re-enable word");
    expect_run(13, "R8 full first period");

    do_write(fld(0, 1, 1) | fld(1, 1, 0), 1'b1);
    check_rdata("R9 change word");
    expect_run(16, "R9 change between pulses");

    t = cyc + 3;
    while (!exp_tick(0, t)) t++;
    wait_until(t - 1);
    do_write(fld(0, 1, 5) | fld(1, 1, 0), 1'b1);
    check(cyc == t, "R9 collision timing", cyc, t);
    expect_run(20, "R9 change on pulse edge");

    do_write('1, 1'b0);
    check_rdata("R2 user write while running");
    expect_run(8, "R2 running ticks");

    do_write('1, 1'b1);
    check_rdata("R7 unused bits zero");
    check(cfg_rdata_o[31:27] == 5'd0, "R7 top bits", cfg_rdata_o[31:27], 0);
    expect_run(262, "R6 R7 period 256");

    do_write('0, 1'b1);
    check_rdata("R5 all disabled word");
    expect_run(6, "R5 all quiet");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule